// File: doc/BRIEF.md
# Store-Multiple Line-Wrap Burst Splitter

This block turns one store-multiple request into at most two write bursts on a 64-bit write path. A request carries a byte address and a count of 32-bit words. The address bits just above the word-byte bits select a word inside an aligned line of `LINE_WORDS` words (eight words, 32 bytes, by default). The block never lets a burst leave that line. The words that fit between the start word and the end of the line go out first. Any remaining words go out as a second burst that starts again at the base of the same line, not the next one.

For each burst the block presents an address beat: address, burst kind, transfer size, beat count minus one, and the byte strobe of the first data beat. It then takes write words one at a time from a word stream and packs them into 64-bit data beats. The word with the even index sits in the lower 32 bits and the word with the odd index sits in the upper 32 bits. All three streams use valid/ready. A transfer happens on a rising edge where both valid and ready are high. Once valid is raised, the payload must stay unchanged until that transfer happens. The block follows this rule on its address and data outputs and relies on the word source following it too. The downstream side may hold ready low for as long as it needs, and the block simply waits. The request port and the reject flag are plain control signals.

Top module: `stm_line_splitter`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1 and `aw_valid`, `w_valid` and `req_err` are 0.
- R2: A request is taken only while the block is idle (`req_ready` high). `req_ready` stays low from acceptance until the last data beat of the last burst has transferred.
- R3: With start word w (address bits [4:2]) and count n, the first burst starts at line offset 4·w and carries min(n, 8−w) words. A non-zero remainder forms a second burst at line offset 0. The address bits above the line offset are passed through unchanged.
- R4: A one-word burst uses transfer size code 2 (4 bytes) and length 0. Its first strobe is 0x0F for an even word and 0xF0 for an odd word.
- R5: A burst of two or more words uses burst code 2'b01 (incrementing) and size code 3 (8 bytes). Its length is ceil((w mod 2 + words)/2) − 1. Its first strobe is 0xF0 when it starts on an odd word and 0xFF otherwise. Every burst carries burst code 2'b01.
- R6: Data beats carry the words in stream order. A beat holding two words has strobe 0xFF, with the lower-indexed word in bits [31:0]. A beat holding a single word has strobe 0x0F (even word, in bits [31:0]) or 0xF0 (odd word, in bits [63:32]), and its unused half is zero. Every word of the request is taken from the word stream exactly once.
- R7: `w_last` is high on exactly the final beat of each burst. `w_valid` is low in the cycle after that beat transfers.
- R8: A burst's data beats follow its address transfer. The second address is offered only after the first burst's last beat has transferred. `aw_valid` and `w_valid` are never high together.
- R9: A request with n = 0, or with n > 16 − w (which would need a third burst), raises `req_err` for exactly the cycle after its acceptance. It issues no address and leaves the block idle.
- R10: While `aw_valid` is high and `aw_ready` low, the address beat holds. While `w_valid` is high and `w_ready` low, the data beat holds, provided the word source holds its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this edge if valid |
| req_addr | input | ADDR_W | Start byte address |
| req_count | input | CNT_W | Number of 32-bit words |
| req_err | output | 1 | One-cycle pulse: request rejected |
| aw_valid | output | 1 | Address beat valid |
| aw_ready | input | 1 | Address beat accepted |
| aw_addr | output | ADDR_W | Burst start address |
| aw_burst | output | 2 | Burst kind, 2'b01 incrementing |
| aw_size | output | 3 | log2 of bytes per beat |
| aw_len | output | 8 | Beats minus one |
| aw_strb_first | output | STRB_W | Byte strobe of the first data beat |
| wd_valid | input | 1 | Write word present |
| wd_ready | output | 1 | Write word taken |
| wd_data | input | WORD_W | Write word |
| w_valid | output | 1 | Data beat valid |
| w_ready | input | 1 | Data beat accepted |
| w_data | output | BEAT_W | Packed data beat |
| w_strb | output | STRB_W | Byte strobe of the beat |
| w_last | output | 1 | Final beat of the burst |

## Verification
The bench builds the block with its defaults: 8-word lines, 32-bit words and 32-bit addresses. The count port is 5 bits wide, so every start word from 0 to 7 can be combined with every count from 0 to 17, plus the largest code, 31. That covers every legal split, every reject boundary n = 17 − w, and every pairing of start and end parity. Each case runs twice, with different upper address bits and different stall patterns on the address, data and word streams, so back-pressure hits each beat position.

// File: rtl/stm_split_pkg.sv
package stm_split_pkg;
  localparam logic [1:0] BURST_INCR = 2'b01;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} split_state_t;
endpackage

// File: rtl/stm_split_plan.sv
// Splits a request into a head burst (up to the end of the line) and a
// wrapped tail burst at the line base; flags requests needing a third.
module stm_split_plan #(
  parameter int LINE_WORDS = 8,
  parameter int IDX_W      = 3,
  parameter int CNT_W      = 5
) (
  input  logic [IDX_W-1:0] start_idx,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] head_cnt,
  output logic [CNT_W-1:0] tail_cnt,
  output logic             reject
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] room;
  logic [SUM_W-1:0] cnt_x;
  logic [SUM_W-1:0] head_x;

  always_comb begin
    room     = SUM_W'(LINE_WORDS) - SUM_W'(start_idx);
    cnt_x    = SUM_W'(count);
    head_x   = (cnt_x < room) ? cnt_x : room;
    reject   = (count == '0) || (cnt_x > room + SUM_W'(LINE_WORDS));
    head_cnt = CNT_W'(head_x);
    tail_cnt = CNT_W'(cnt_x - head_x);
  end
endmodule

// File: rtl/stm_split_aw.sv
// Derives size, length and first strobe of one burst from its start word
// and word count.
module stm_split_aw #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 5
) (
  input  logic [IDX_W-1:0]        start_idx,
  input  logic [CNT_W-1:0]        word_cnt,
  output logic [2:0]              size_code,
  output logic [7:0]              len_code,
  output logic [(2*WORD_W)/8-1:0] strb_first
);
  localparam int STRB_W    = (2 * WORD_W) / 8;
  localparam int HALF      = STRB_W / 2;
  localparam int WORD_SIZE = $clog2(WORD_W / 8);
  localparam int BT_W      = CNT_W + 1;
  localparam logic [STRB_W-1:0] LO_MASK = STRB_W'({HALF{1'b1}});
  localparam logic [STRB_W-1:0] HI_MASK = LO_MASK << HALF;

  logic [BT_W-1:0] beats;
  logic            odd_start;

  always_comb begin
    odd_start = start_idx[0];
    beats = (BT_W'(odd_start) + BT_W'(word_cnt) + BT_W'(1)) >> 1;
    if (word_cnt == CNT_W'(1)) begin
      size_code  = 3'(WORD_SIZE);
      len_code   = 8'd0;
      strb_first = odd_start ? HI_MASK : LO_MASK;
    end else begin
      size_code  = 3'(WORD_SIZE + 1);
      len_code   = 8'(beats - BT_W'(1));
      strb_first = odd_start ? HI_MASK : (LO_MASK | HI_MASK);
    end
  end
endmodule

// File: rtl/stm_split_pack.sv
// Packs 32-bit words into 64-bit beats for one burst. A two-word beat
// parks its lower word in a holding register; the upper word passes
// straight through, so no beat is buffered beyond that one word.
module stm_split_pack #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [IDX_W-1:0]        load_start,
  input  logic [CNT_W-1:0]        load_cnt,
  input  logic                    active,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [WORD_W-1:0]       s_data,
  output logic                    w_valid,
  input  logic                    w_ready,
  output logic [2*WORD_W-1:0]     w_data,
  output logic [(2*WORD_W)/8-1:0] w_strb,
  output logic                    w_last
);
  localparam int STRB_W = (2 * WORD_W) / 8;
  localparam int HALF   = STRB_W / 2;
  localparam logic [STRB_W-1:0] LO_MASK = STRB_W'({HALF{1'b1}});
  localparam logic [STRB_W-1:0] HI_MASK = LO_MASK << HALF;

  logic [IDX_W-1:0]  cur_idx;
  logic [CNT_W-1:0]  left;
  logic [WORD_W-1:0] hold;
  logic              have_lo;
  logic              pair;
  logic [CNT_W-1:0]  step;

  always_comb begin
    pair    = !cur_idx[0] && (left >= CNT_W'(2));
    step    = pair ? CNT_W'(2) : CNT_W'(1);
    s_ready = 1'b0;
    w_valid = 1'b0;
    if (active) begin
      if (pair && !have_lo) begin
        s_ready = 1'b1;
      end else begin
        w_valid = s_valid;
        s_ready = w_ready;
      end
    end
    if (pair) begin
      w_data = {s_data, hold};
      w_strb = LO_MASK | HI_MASK;
    end else if (cur_idx[0]) begin
      w_data = {s_data, {WORD_W{1'b0}}};
      w_strb = HI_MASK;
    end else begin
      w_data = {{WORD_W{1'b0}}, s_data};
      w_strb = LO_MASK;
    end
    w_last = (left == step);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_idx <= '0;
      left    <= '0;
      hold    <= '0;
      have_lo <= 1'b0;
    end else if (load) begin
      cur_idx <= load_start;
      left    <= load_cnt;
      have_lo <= 1'b0;
    end else if (active) begin
      if (s_valid && s_ready && pair && !have_lo) begin
        hold    <= s_data;
        have_lo <= 1'b1;
      end
      if (w_valid && w_ready) begin
        cur_idx <= cur_idx + IDX_W'(step);
        left    <= left - step;
        have_lo <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stm_line_splitter.sv
module stm_line_splitter #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  localparam int BEAT_W    = 2 * WORD_W,
  localparam int STRB_W    = BEAT_W / 8,
  localparam int IDX_W     = $clog2(LINE_WORDS),
  localparam int WB_W      = $clog2(WORD_W / 8),
  localparam int OFF_W     = IDX_W + WB_W,
  localparam int CNT_W     = $clog2(2 * LINE_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  output logic              req_err,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic [ADDR_W-1:0] aw_addr,
  output logic [1:0]        aw_burst,
  output logic [2:0]        aw_size,
  output logic [7:0]        aw_len,
  output logic [STRB_W-1:0] aw_strb_first,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [WORD_W-1:0] wd_data,
  output logic              w_valid,
  input  logic              w_ready,
  output logic [BEAT_W-1:0] w_data,
  output logic [STRB_W-1:0] w_strb,
  output logic              w_last
);
  import stm_split_pkg::*;

  split_state_t             state;
  logic                     tail_phase;
  logic [ADDR_W-OFF_W-1:0]  line_tag;
  logic [IDX_W-1:0]         head_start;
  logic [CNT_W-1:0]         head_cnt_q;
  logic [CNT_W-1:0]         tail_cnt_q;
  logic                     err_q;

  logic [CNT_W-1:0]         plan_head;
  logic [CNT_W-1:0]         plan_tail;
  logic                     plan_reject;
  logic [IDX_W-1:0]         cur_start;
  logic [CNT_W-1:0]         cur_cnt;
  logic                     unused_low_bits;

  assign unused_low_bits = ^req_addr[WB_W-1:0];

  stm_split_plan #(
    .LINE_WORDS(LINE_WORDS), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_plan (
    .start_idx (req_addr[OFF_W-1:WB_W]),
    .count     (req_count),
    .head_cnt  (plan_head),
    .tail_cnt  (plan_tail),
    .reject    (plan_reject)
  );

  assign cur_start = tail_phase ? '0 : head_start;
  assign cur_cnt   = tail_phase ? tail_cnt_q : head_cnt_q;

  stm_split_aw #(
    .WORD_W(WORD_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_aw (
    .start_idx  (cur_start),
    .word_cnt   (cur_cnt),
    .size_code  (aw_size),
    .len_code   (aw_len),
    .strb_first (aw_strb_first)
  );

  assign req_ready = (state == ST_IDLE);
  assign req_err   = err_q;
  assign aw_valid  = (state == ST_ADDR);
  assign aw_addr   = {line_tag, cur_start, {WB_W{1'b0}}};
  assign aw_burst  = BURST_INCR;

  stm_split_pack #(
    .WORD_W(WORD_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (aw_valid && aw_ready),
    .load_start (cur_start),
    .load_cnt   (cur_cnt),
    .active     (state == ST_DATA),
    .s_valid    (wd_valid),
    .s_ready    (wd_ready),
    .s_data     (wd_data),
    .w_valid    (w_valid),
    .w_ready    (w_ready),
    .w_data     (w_data),
    .w_strb     (w_strb),
    .w_last     (w_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tail_phase <= 1'b0;
      line_tag   <= '0;
      head_start <= '0;
      head_cnt_q <= '0;
      tail_cnt_q <= '0;
      err_q      <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (plan_reject) begin
              err_q <= 1'b1;
            end else begin
              line_tag   <= req_addr[ADDR_W-1:OFF_W];
              head_start <= req_addr[OFF_W-1:WB_W];
              head_cnt_q <= plan_head;
              tail_cnt_q <= plan_tail;
              tail_phase <= 1'b0;
              state      <= ST_ADDR;
            end
          end
        end
        ST_ADDR: begin
          if (aw_ready) state <= ST_DATA;
        end
        ST_DATA: begin
          if (w_valid && w_ready && w_last) begin
            if (!tail_phase && (tail_cnt_q != '0)) begin
              tail_phase <= 1'b1;
              state      <= ST_ADDR;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stm_split_check.sv
module stm_split_check #(
  parameter int ADDR_W = 32,
  parameter int STRB_W = 8,
  parameter int BEAT_W = 64,
  parameter int OFF_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_err,
  input logic              aw_valid,
  input logic              aw_ready,
  input logic [ADDR_W-1:0] aw_addr,
  input logic [1:0]        aw_burst,
  input logic [2:0]        aw_size,
  input logic [7:0]        aw_len,
  input logic [STRB_W-1:0] aw_strb_first,
  input logic              w_valid,
  input logic              w_ready,
  input logic [BEAT_W-1:0] w_data,
  input logic [STRB_W-1:0] w_strb,
  input logic              w_last
);
  localparam logic [STRB_W-1:0] LO_M = STRB_W'({(STRB_W/2){1'b1}});
  localparam logic [STRB_W-1:0] HI_M = LO_M << (STRB_W / 2);

  p_busy_blocks_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid || w_valid) |-> !req_ready);

  p_tail_at_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && $past(w_valid && w_ready && w_last)) |-> (aw_addr[OFF_W-1:0] == '0));

  p_single_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && aw_size == 3'd2) |-> (aw_len == 8'd0 && $countones(aw_strb_first) == STRB_W/2));

  p_incr_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> (aw_burst == 2'b01));

  p_lane_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid |-> (w_strb == LO_M || w_strb == HI_M || w_strb == (LO_M | HI_M)));

  p_last_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && w_ready && w_last) |=> !w_valid);

  p_one_channel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(aw_valid && w_valid));

  p_reject_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> ($past(req_valid && req_ready) && req_ready && !aw_valid));

  p_aw_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && !aw_ready) |=> (aw_valid && $stable(aw_addr) && $stable(aw_len)
                                 && $stable(aw_size) && $stable(aw_strb_first)));

  p_w_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && !w_ready) |=> (w_valid && $stable(w_data) && $stable(w_strb) && $stable(w_last)));
endmodule

bind stm_line_splitter stm_split_check #(
  .ADDR_W(ADDR_W), .STRB_W(STRB_W), .BEAT_W(BEAT_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_err(req_err), .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
  .aw_burst(aw_burst), .aw_size(aw_size), .aw_len(aw_len),
  .aw_strb_first(aw_strb_first), .w_valid(w_valid), .w_ready(w_ready),
  .w_data(w_data), .w_strb(w_strb), .w_last(w_last)
);

// File: tb/stm_line_splitter_test.sv
`timescale 1ns/1ps
module stm_line_splitter_test;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CNT_W-1:0]  req_count = '0;
  logic              req_err;
  logic              aw_valid;
  logic              aw_ready = 1'b0;
  logic [ADDR_W-1:0] aw_addr;
  logic [1:0]        aw_burst;
  logic [2:0]        aw_size;
  logic [7:0]        aw_len;
  logic [7:0]        aw_strb_first;
  logic              wd_valid = 1'b0;
  logic              wd_ready;
  logic [WORD_W-1:0] wd_data = '0;
  logic              w_valid;
  logic              w_ready = 1'b0;
  logic [63:0]       w_data;
  logic [7:0]        w_strb;
  logic              w_last;

  always #2.5 clk = ~clk;

  stm_line_splitter uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_count(req_count), .req_err(req_err),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
    .aw_burst(aw_burst), .aw_size(aw_size), .aw_len(aw_len),
    .aw_strb_first(aw_strb_first), .wd_valid(wd_valid), .wd_ready(wd_ready),
    .wd_data(wd_data), .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
    .w_strb(w_strb), .w_last(w_last)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input int id, input int i);
    return {8'hC3, 8'(id), 16'(i)};
  endfunction

  task automatic run_req(input int w, input int n, input logic [26:0] tag,
                         input int pat, input int id);
    int room, c0, c1, nops, sent, opi, cw, rem, gw, cyc, nw;
    bit rej, open, busy_bad, order_bad, pend;
    logic [63:0] exp_d;
    logic [7:0]  exp_s;
    int s, c;
    room = 8 - w;
    rej  = (n == 0) || (n > 16 - w);
    c0   = (n < room) ? n : room;
    c1   = n - c0;
    nops = rej ? 0 : ((c1 != 0) ? 2 : 1);

    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = {tag, 3'(w), 2'b00};
    req_count = 5'(n);
    #1 check("R2", "req_ready when idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9", "req_err after accept", 64'(req_err), 64'(rej));
    if (rej) begin
      busy_bad = 1'b0;
      for (int k = 0; k < 3; k++) begin
        if (aw_valid || !req_ready) busy_bad = 1'b1;
        @(negedge clk);
        if (req_err) busy_bad = 1'b1;
      end
      check("R9", "reject leaves block idle, one-cycle flag", 64'(busy_bad), 64'd0);
      return;
    end

    sent = 0; opi = 0; open = 1'b0; cw = 0; rem = 0; gw = 0; cyc = 0;
    busy_bad = 1'b0; order_bad = 1'b0; pend = 1'b0;
    while ((opi < nops || open) && cyc < 300) begin
      if (!pend) wd_valid = (sent < n) && (((cyc + pat) % 3) != 0);
      wd_data  = word_of(id, sent);
      aw_ready = ((cyc + pat) % 4) != 1;
      w_ready  = ((cyc * 3 + pat) % 5) != 2;
      #1;
      if (req_ready) busy_bad = 1'b1;
      if (aw_valid && w_valid) order_bad = 1'b1;
      if (aw_valid && aw_ready) begin
        if (open || opi >= nops) order_bad = 1'b1;
        s = (opi == 0) ? w : 0;
        c = (opi == 0) ? c0 : c1;
        check("R3", "aw_addr", 64'(aw_addr), 64'({tag, 3'(s), 2'b00}));
        check("R5", "aw_burst", 64'(aw_burst), 64'd1);
        if (c == 1) begin
          check("R4", "aw_size single", 64'(aw_size), 64'd2);
          check("R4", "aw_len single", 64'(aw_len), 64'd0);
          check("R4", "strobe single", 64'(aw_strb_first),
                (s % 2 == 1) ? 64'hF0 : 64'h0F);
        end else begin
          check("R5", "aw_size", 64'(aw_size), 64'd3);
          check("R5", "aw_len", 64'(aw_len), 64'(((s % 2) + c + 1) / 2 - 1));
          check("R5", "first strobe", 64'(aw_strb_first),
                (s % 2 == 1) ? 64'hF0 : 64'hFF);
        end
        open = 1'b1; cw = s; rem = c; opi++;
      end
      if (w_valid && w_ready) begin
        if (!open) order_bad = 1'b1;
        else begin
          nw = ((cw % 2 == 0) && rem >= 2) ? 2 : 1;
          if (nw == 2) begin
            exp_d = {word_of(id, gw + 1), word_of(id, gw)};
            exp_s = 8'hFF;
          end else if (cw % 2 == 1) begin
            exp_d = {word_of(id, gw), 32'h0};
            exp_s = 8'hF0;
          end else begin
            exp_d = {32'h0, word_of(id, gw)};
            exp_s = 8'h0F;
          end
          check("R6", "w_data", w_data, exp_d);
          check("R6", "w_strb", 64'(w_strb), 64'(exp_s));
          check("R7", "w_last", 64'(w_last), 64'(rem == nw));
          cw += nw; rem -= nw; gw += nw;
          if (rem == 0) open = 1'b0;
        end
      end
      if (wd_valid && wd_ready) begin
        sent++;
        pend = 1'b0;
      end else begin
        pend = wd_valid;
      end
      @(negedge clk);
      cyc++;
    end
    wd_valid = 1'b0;
    aw_ready = 1'b0;
    w_ready  = 1'b0;
    check("R8", "watchdog: request completes", 64'(cyc >= 300), 64'd0);
    check("R8", "address/data ordering", 64'(order_bad), 64'd0);
    check("R2", "req_ready low while busy", 64'(busy_bad), 64'd0);
    check("R6", "words taken from stream", 64'(sent), 64'(n));
    #1;
    check("R7", "w_valid drops after last", 64'(w_valid), 64'd0);
    check("R2", "idle after request", 64'(req_ready), 64'd1);
  endtask

  initial begin
    int id;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "req_ready in reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "req_ready", 64'(req_ready), 64'd1);
    check("R1", "aw_valid", 64'(aw_valid), 64'd0);
    check("R1", "w_valid", 64'(w_valid), 64'd0);
    check("R1", "req_err", 64'(req_err), 64'd0);
    id = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int w = 0; w < 8; w++) begin
        for (int n = 0; n <= 17; n++) begin
          run_req(w, n, (pass == 0) ? 27'h0000123 : 27'h5A5A5A5, pass * 7 + w + n, id);
          id++;
        end
      end
    end
    run_req(0, 31, 27'h7FFFFFF, 1, id);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R8 watchdog: actual expired expected finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule